// File: doc/BRIEF.md
# Alert Pin Controller with Host Inactivity Watchdog

This block drives one alert output pin toward a host processor. Several internal condition flags (key activity, error states and the like) are each gated by an enable bit of a configuration byte. The enabled flags are OR-combined, and the result is driven onto the pin at a selectable polarity. The host can wire the pin to an edge-sensitive interrupt and poll the rest of the device only when the pin changes.

The same pin can also act as a watchdog for the host. When the watchdog enable bit is set, the first host command arms an inactivity counter, and every later command restarts it. If no command arrives for `TIMEOUT_TICKS` clocks, the pin is forced active for `PULSE_TICKS` clocks, which the host can use as a reset. The watchdog then disarms until the next command. While the device sleeps, the pin keeps its level and the watchdog is frozen. The configuration byte resets to 0x6C and is replaced through a write strobe.

Top module: `alert_pin_ctrl`

## Requirements
- R1: After reset the pin is low and the configuration byte is 0x6C. In that state sources 1, 2, 4 and 5 are enabled, the watchdog is off and the polarity is active-high.
- R2: Configuration bit i+1 enables condition source i (i = 0..5). The pin is active one clock after any enabled source is high, with the enabled sources OR-combined.
- R3: A condition source whose enable bit is 0 has no effect on the pin.
- R4: Configuration bit 7 = 1 inverts the pin, so the active level is low and the idle level is high.
- R5: Configuration bit 0 enables the watchdog. While it is 0 no watchdog pulse occurs, and clearing it discards any armed count.
- R6: After reset the watchdog is not armed. Without a host command no watchdog pulse ever occurs.
- R7: When armed, if no command arrives, the pin goes active TIMEOUT_TICKS+1 clocks after the clock edge that sampled the last command. It stays active for exactly PULSE_TICKS clocks, and the watchdog then stays disarmed until a new command.
- R8: Each host command sampled while armed restarts the inactivity count.
- R9: While `sleep` is high the pin holds its level, the watchdog count is frozen and host commands are ignored.
- R10: A `cfg_wr` strobe loads `cfg_data` at that clock edge, and the pin reflects the new byte at the following edge.
- R11: A host command sampled during a watchdog pulse neither lengthens the pulse nor re-arms the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond | input | 6 | Internal condition flags, bit i is source i |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration byte to load |
| host_cmd | input | 1 | One-clock strobe per host command received |
| sleep | input | 1 | Device sleep indicator |
| alert_pin | output | 1 | Alert pin level (registered) |

## Verification
A condition change shows on the pin one clock after the edge that samples it. A configuration write shows two edges after the strobe is driven: one edge to load the register and one more to update the pin. A watchdog pulse starts TIMEOUT_TICKS+1 edges after the command edge, less any edges spent asleep. The bench drives inputs on falling edges and runs a behavioural countdown model on every rising edge. It compares the pin with that model at each falling edge. It also measures watchdog rise delays and pulse widths directly in clock counts against these figures.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int CFG_W      = 8;
  localparam int WD_EN_BIT  = 0;
  localparam int SRC_LSB    = 1;
  localparam int POL_BIT    = 7;
  localparam int N_SRC      = POL_BIT - SRC_LSB;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h6C;

  // packed MSB first: invert is bit 7, src_en bits 6:1, wd_en bit 0
  typedef struct packed {
    logic             invert;
    logic [N_SRC-1:0] src_en;
    logic             wd_en;
  } cfg_t;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_ARMED = 2'd1,
    WD_PULSE = 2'd2
  } wd_state_e;
endpackage

// File: rtl/alert_cfg_reg.sv
module alert_cfg_reg
  import alert_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] data,
  output cfg_t             cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)      cfg_q <= CFG_RESET;
    else if (wr)  cfg_q <= data;
  end

  assign cfg_o = cfg_t'(cfg_q);

  a_r1_reset_cfg: assert property (@(posedge clk)
    $past(rst) |-> (cfg_o == cfg_t'(CFG_RESET)));

  a_r10_cfg_load: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cfg_o == cfg_t'($past(data))));

  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(cfg_o));
endmodule

// File: rtl/alert_src_mask.sv
module alert_src_mask #(
  parameter int N = 6
) (
  input  logic [N-1:0] cond,
  input  logic [N-1:0] en,
  output logic         any_o
);
  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = cond[i] & en[i];
  end

  assign any_o = |gated;

  always_comb begin
    if (!$isunknown(en) && !$isunknown(cond))
      a_r3_masked_off: assert ((en == '0) -> !any_o);
  end
endmodule

// File: rtl/alert_host_wdog.sv
module alert_host_wdog
  import alert_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 400_000_000,
  parameter int PULSE_TICKS   = 2_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic freeze,
  input  logic cmd,
  output logic pulse_o
);
  localparam int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam int PW = (PULSE_TICKS   > 1) ? $clog2(PULSE_TICKS)   : 1;
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_TICKS - 1);
  localparam logic [PW-1:0] P_LAST = PW'(PULSE_TICKS - 1);

  wd_state_e       st;
  logic [TW-1:0]   cnt;
  logic [PW-1:0]   pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= WD_IDLE;
      cnt  <= '0;
      pcnt <= '0;
    end else if (!freeze) begin
      if (!enable) begin
        st   <= WD_IDLE;
        cnt  <= '0;
        pcnt <= '0;
      end else begin
        case (st)
          WD_IDLE: begin
            if (cmd) begin
              st  <= WD_ARMED;
              cnt <= '0;
            end
          end
          WD_ARMED: begin
            if (cmd) begin
              cnt <= '0;
            end else if (cnt == T_LAST) begin
              st   <= WD_PULSE;
              pcnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          WD_PULSE: begin
            if (pcnt == P_LAST) st <= WD_IDLE;
            else                pcnt <= pcnt + 1'b1;
          end
          default: st <= WD_IDLE;
        endcase
      end
    end
  end

  assign pulse_o = (st == WD_PULSE);

  a_r5_off_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (!enable && !freeze) |=> !pulse_o);

  a_r6_arm_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    (st == WD_IDLE && !cmd) |=> (st != WD_ARMED));

  a_r8_cmd_restart: assert property (@(posedge clk) disable iff (rst)
    (enable && !freeze && cmd && st != WD_PULSE) |=> (st == WD_ARMED && cnt == '0));

  a_r7_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> (pcnt <= P_LAST));

  a_r9_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    freeze |=> ($stable(st) && $stable(cnt) && $stable(pcnt)));

  a_r11_no_rearm_from_pulse: assert property (@(posedge clk) disable iff (rst)
    (st == WD_PULSE) |=> (st != WD_ARMED));
endmodule

// File: rtl/alert_pin_ctrl.sv
module alert_pin_ctrl
  import alert_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 400_000_000,
  parameter int PULSE_TICKS   = 2_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] cond,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             host_cmd,
  input  logic             sleep,
  output logic             alert_pin
);
  cfg_t cfg;
  logic src_any;
  logic wd_pulse;
  logic alert_q;

  alert_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .data  (cfg_data),
    .cfg_o (cfg)
  );

  alert_src_mask #(.N(N_SRC)) u_mask (
    .cond  (cond),
    .en    (cfg.src_en),
    .any_o (src_any)
  );

  alert_host_wdog #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .PULSE_TICKS   (PULSE_TICKS)
  ) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .enable  (cfg.wd_en),
    .freeze  (sleep),
    .cmd     (host_cmd),
    .pulse_o (wd_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)         alert_q <= 1'b0;
    else if (!sleep) alert_q <= (src_any | wd_pulse) ^ cfg.invert;
  end

  assign alert_pin = alert_q;

  a_r1_reset_low: assert property (@(posedge clk)
    $past(rst) |-> !alert_pin);

  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (rst)
    sleep |=> $stable(alert_pin));

  a_r2_cond_active: assert property (@(posedge clk) disable iff (rst)
    (!sleep && src_any && !cfg.invert) |=> alert_pin);

  a_r4_inverted_active: assert property (@(posedge clk) disable iff (rst)
    (!sleep && src_any && cfg.invert) |=> !alert_pin);

  a_r7_pulse_drives: assert property (@(posedge clk) disable iff (rst)
    (!sleep && wd_pulse && !cfg.invert) |=> alert_pin);
endmodule

// File: tb/alert_pin_ctrl_bench.sv
`timescale 1ns/1ps
module alert_pin_ctrl_bench;
  localparam int T = 40;
  localparam int P = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cond = '0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       host_cmd = 1'b0;
  logic       sleep = 1'b0;
  logic       alert_pin;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  alert_pin_ctrl #(.TIMEOUT_TICKS(T), .PULSE_TICKS(P)) u_alert_pin_ctrl (
    .clk(clk), .rst(rst), .cond(cond), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .host_cmd(host_cmd), .sleep(sleep), .alert_pin(alert_pin)
  );

  // behavioural reference: countdown to expiry, countdown of pulse
  logic [7:0] m_cfg = 8'h6C;
  bit   m_arm = 0;
  int   m_left = 0;
  int   m_pulse = 0;
  logic m_pin = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 8'h6C; m_arm = 0; m_left = 0; m_pulse = 0; m_pin = 1'b0;
    end else begin
      if (!sleep)
        m_pin = ((|(cond & m_cfg[6:1])) || (m_pulse > 0)) ^ m_cfg[7];
      if (!sleep) begin
        if (!m_cfg[0]) begin
          m_arm = 0; m_left = 0; m_pulse = 0;
        end else if (m_pulse > 0) begin
          m_pulse = m_pulse - 1;
        end else if (host_cmd) begin
          m_arm = 1; m_left = T;
        end else if (m_arm) begin
          m_left = m_left - 1;
          if (m_left == 0) begin m_arm = 0; m_pulse = P; end
        end
      end
      if (cfg_wr) m_cfg = cfg_data;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      checks++;
      if (alert_pin !== m_pin) begin
        errors++;
        $display("FAIL %s model compare: pin=%0b expected %0b at %0t", phase, alert_pin, m_pin, $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_data = v;
    tick(1);
    cfg_wr = 1'b0;
    tick(1);
  endtask

  task automatic cmd_pulse();
    host_cmd = 1'b1;
    tick(1);
    host_cmd = 1'b0;
  endtask

  task automatic wait_rise(output int k);
    k = 0;
    while (alert_pin !== 1'b1 && k < 6*T) begin tick(1); k++; end
  endtask

  task automatic wait_fall(output int w);
    w = 0;
    while (alert_pin === 1'b1 && w < 6*P) begin tick(1); w++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k, w;
    tick(3);
    rst = 1'b0;
    tick(1);
    cmp_en = 1;
    phase = "R1";
    expect_val("R1 reset pin low", alert_pin, 0);
    cond = 6'b001001; tick(2);
    expect_val("R1 default disables sources 0,3", alert_pin, 0);
    cond = 6'b000010; tick(1);
    expect_val("R1 default enables source 1", alert_pin, 1);

    phase = "R2";
    for (int i = 0; i < 6; i++) begin
      cond = 6'(1 << i); tick(1);
      expect_val($sformatf("R2 single source %0d", i), alert_pin, (8'h6C >> (i+1)) & 1);
    end
    cond = 6'b110000; tick(1);
    expect_val("R2 OR of two enabled", alert_pin, 1);
    cond = 6'b000000; tick(1);
    expect_val("R2 idle low", alert_pin, 0);

    phase = "R10";
    cond = 6'b000001;
    write_cfg(8'h7E);
    expect_val("R10 new enable for source 0", alert_pin, 1);

    phase = "R4";
    cond = '0;
    write_cfg(8'hFE);
    expect_val("R4 inverted idle high", alert_pin, 1);
    cond = 6'b100000; tick(1);
    expect_val("R4 inverted active low", alert_pin, 0);

    phase = "R3";
    cond = 6'b111111;
    write_cfg(8'h01);
    expect_val("R3 all sources masked", alert_pin, 0);
    cond = '0;

    phase = "R6";
    tick(3*T);
    expect_val("R6 no pulse before first command", alert_pin, 0);

    phase = "R7";
    cmd_pulse();
    wait_rise(k);
    expect_val("R7 rise delay", k, T+1);
    wait_fall(w);
    expect_val("R7 pulse width", w, P);
    tick(3*T);
    expect_val("R7 disarmed after pulse", alert_pin, 0);

    phase = "R8";
    for (int r = 0; r < 4; r++) begin
      cmd_pulse();
      tick(T/2);
    end
    expect_val("R8 restarted count keeps pin low", alert_pin, 0);
    cmd_pulse();
    wait_rise(k);
    expect_val("R8 rise delay from last command", k, T+1);
    wait_fall(w);

    phase = "R11";
    cmd_pulse();
    wait_rise(k);
    host_cmd = 1'b1; tick(1); host_cmd = 1'b0;
    wait_fall(w);
    expect_val("R11 pulse width with command inside", w+1, P);
    tick(2*T);
    expect_val("R11 no re-arm from command in pulse", alert_pin, 0);

    phase = "R5";
    cmd_pulse();
    tick(T/2);
    write_cfg(8'h00);
    tick(2*T);
    expect_val("R5 disabled watchdog no pulse", alert_pin, 0);
    write_cfg(8'h01);
    tick(2*T);
    expect_val("R5 clearing enable dropped armed count", alert_pin, 0);

    phase = "R9";
    write_cfg(8'h7E);
    cond = 6'b000001; tick(1);
    expect_val("R9 active before sleep", alert_pin, 1);
    sleep = 1'b1; cond = '0; tick(5);
    expect_val("R9 held during sleep", alert_pin, 1);
    sleep = 1'b0; tick(1);
    expect_val("R9 follows after wake", alert_pin, 0);
    write_cfg(8'h01);
    cmd_pulse();
    tick(T/2);
    sleep = 1'b1;
    tick(T);
    host_cmd = 1'b1; tick(1); host_cmd = 1'b0;
    tick(2*T);
    expect_val("R9 watchdog frozen in sleep", alert_pin, 0);
    sleep = 1'b0;
    wait_rise(k);
    expect_val("R9 remaining count after wake", k, T/2 + 1);
    wait_fall(w);
    tick(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule